// File: doc/BRIEF.md
# Manchester Configuration Dump Transmitter

This block serialises a range of configuration bytes onto one open-drain sink-enable line while a test request is held active. It fetches each byte through a synchronous memory read port, wraps it in a frame, and sends the frame as two-phase Manchester half-bits. Each frame is a start bit of value 1, then the eight data bits most significant first, then a quiet gap in the off state. The sink line has two states: 1 turns the current sink on (line low, L) and 0 leaves it off (high impedance, Z).

The two-bit mode code and a source-select bit are sampled when the dump begins, and together they set the address range and the memory source. Removing the request stops the dump at once and returns the line to Z. After the last byte of the range, the block stays silent until the request is removed and then applied again. Two half-bit periods are available, chosen by a rate-select bit. Each is given as a parameter counted in system clocks.

Top module: `cfg_dump_tx`

## Requirements
- R1: A dump starts only when `test_req` is 1 and `mode[0]` is 1. With mode 00 or 10, or with `test_req` low, `busy`, `sink_on` and `mem_rd` stay 0.
- R2: Mode 01 with `src_live`=0 reads addresses 0x24 up to 0x7F in ascending order with `mem_src`=0.
- R3: Mode 01 with `src_live`=1 reads addresses 0x3B up to 0x43 in ascending order with `mem_src`=1.
- R4: Mode 11 reads addresses 0x00 up to 0x7F in ascending order with `mem_src`=0, whatever the value of `src_live`.
- R5: A bit of value 1 drives `sink_on` to 1 for its first half and 0 for its second. A bit of value 0 drives 0 and then 1. Each half lasts exactly DIV_FAST clocks when `fast`=1 and DIV_SLOW clocks when `fast`=0.
- R6: A frame sends a start bit of 1 and then the fetched byte, most significant bit first, for 18 half-bits in total.
- R7: Every frame, the first one included, is preceded by a gap of 2*PAUSE_BITS half-bits with `sink_on`=0. Consecutive frames therefore start 18+2*PAUSE_BITS half-bits apart when the memory answers within the gap.
- R8: Exactly one single-cycle `mem_rd` pulse is issued per frame, at the start of the gap before that frame. The byte is captured on the cycle where `mem_valid` is 1.
- R9: When `test_req` falls, `sink_on` and `busy` go to 0 in the same cycle. The next activation restarts the dump from the first address of the range.
- R10: After the last frame of the range, `busy` and `sink_on` stay 0 until `test_req` is removed and applied again.
- R11: `busy` is 1 from the cycle after activation until the last frame ends, and `sink_on` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_req | input | 1 | Test request level |
| mode | input | 2 | Dump mode code |
| src_live | input | 1 | Source select: 1 = live registers, 0 = non-volatile store |
| fast | input | 1 | Half-bit rate select: 1 = DIV_FAST, 0 = DIV_SLOW |
| mem_rd | output | 1 | Single-cycle read strobe |
| mem_src | output | 1 | Source of the current read: 1 = live registers |
| mem_addr | output | 7 | Read address |
| mem_data | input | 8 | Read data |
| mem_valid | input | 1 | Read data valid |
| sink_on | output | 1 | Current sink enable: 1 = L, 0 = Z |
| busy | output | 1 | Dump in progress |

## Verification
The request can fall during the same cycle in which the block is issuing a read, or while it is driving a half-bit. In that case the abort has to override both. The bench provokes this by dropping `test_req` in the middle of a frame and again during a gap. It judges the result by sampling `sink_on` and `busy` within the same clock period. After reactivation, the first decoded byte must again belong to the first address of the range. Separately, the memory answer lands in the gap that precedes the frame's first half-bit. The fixed start-to-start spacing of decoded frames shows that the captured byte is ready in time.

// File: rtl/cfg_dump_tx.sv
module cfg_dump_tx #(
  parameter int DIV_FAST   = 39,
  parameter int DIV_SLOW   = 156,
  parameter int PAUSE_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_req,
  input  logic [1:0] mode,
  input  logic       src_live,
  input  logic       fast,
  output logic       mem_rd,
  output logic       mem_src,
  output logic [6:0] mem_addr,
  input  logic [7:0] mem_data,
  input  logic       mem_valid,
  output logic       sink_on,
  output logic       busy
);
  localparam int DMAX   = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW     = $clog2(DMAX + 1);
  localparam int PH     = 2 * PAUSE_BITS;
  localparam int HMAX   = (PH > 18) ? PH : 18;
  localparam int HW     = $clog2(HMAX);
  localparam logic [CW-1:0] RLD_F = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] RLD_S = CW'(DIV_SLOW - 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_SEND, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hcnt;
  logic [6:0]    addr, last;
  logic [7:0]    byte_q;
  logic          src_q, have_q, rd_q;

  wire           act   = test_req & mode[0];
  wire           tick  = (cnt == '0);
  wire [CW-1:0]  rld   = fast ? RLD_F : RLD_S;
  wire [6:0]     first = mode[1] ? 7'h00 : (src_live ? 7'h3B : 7'h24);
  wire [6:0]     lastc = (mode[1] | ~src_live) ? 7'h7F : 7'h43;
  wire [8:0]     frame = {1'b1, byte_q};
  wire [3:0]     bidx  = 4'd8 - 4'(hcnt[HW-1:1]);
  wire           bitv  = frame[bidx];

  assign mem_rd   = rd_q & act;
  assign mem_src  = src_q;
  assign mem_addr = addr;
  assign busy     = act & ((st == S_GAP) | (st == S_SEND));
  assign sink_on  = act & (st == S_SEND) & (hcnt[0] ? ~bitv : bitv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      hcnt   <= '0;
      addr   <= '0;
      last   <= '0;
      byte_q <= '0;
      src_q  <= 1'b0;
      have_q <= 1'b0;
      rd_q   <= 1'b0;
    end else if (!act) begin
      st     <= S_IDLE;
      rd_q   <= 1'b0;
      have_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          st     <= S_GAP;
          addr   <= first;
          last   <= lastc;
          src_q  <= ~mode[1] & src_live;
          cnt    <= rld;
          hcnt   <= '0;
          rd_q   <= 1'b1;
          have_q <= 1'b0;
        end
        S_GAP: begin
          rd_q <= 1'b0;
          if (mem_valid && !have_q) begin
            byte_q <= mem_data;
            have_q <= 1'b1;
          end
          if (tick) begin
            cnt <= rld;
            if (hcnt == HW'(PH - 1)) begin
              if (have_q) begin
                st   <= S_SEND;
                hcnt <= '0;
              end
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_SEND: begin
          if (tick) begin
            cnt <= rld;
            if (hcnt == HW'(17)) begin
              have_q <= 1'b0;
              hcnt   <= '0;
              if (addr == last) begin
                st <= S_DONE;
              end else begin
                addr <= addr + 1'b1;
                st   <= S_GAP;
                rd_q <= 1'b1;
              end
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module cfg_dump_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       test_req,
  input logic [1:0] mode,
  input logic       mem_rd,
  input logic       mem_src,
  input logic [6:0] mem_addr,
  input logic       sink_on,
  input logic       busy
);
  assert_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(test_req && mode[0]));
  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  assert_rd_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
  assert_sink_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sink_on |-> busy);
  assert_live_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_src) |-> (mem_addr >= 7'h3B && mem_addr <= 7'h43));
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_req) |-> (!sink_on && !busy));
endmodule

bind cfg_dump_tx cfg_dump_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .test_req(test_req), .mode(mode),
  .mem_rd(mem_rd), .mem_src(mem_src), .mem_addr(mem_addr),
  .sink_on(sink_on), .busy(busy)
);

// File: tb/sim_cfg_dump_tx.sv
`timescale 1ns/1ps
module sim_cfg_dump_tx;
  localparam int DF = 3;
  localparam int DS = 8;
  localparam int PB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic test_req = 1'b0, src_live = 1'b0, fast = 1'b0;
  logic [1:0] mode = 2'b00;
  logic mem_rd, mem_src, mem_valid = 1'b0, sink_on, busy;
  logic [6:0] mem_addr;
  logic [7:0] mem_data = 8'h00;

  int checks = 0, failures = 0, rd_cnt = 0;
  bit finished = 0;
  logic smp [0:1023];

  always #10 clk = ~clk;

  cfg_dump_tx #(.DIV_FAST(DF), .DIV_SLOW(DS), .PAUSE_BITS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .test_req(test_req), .mode(mode),
    .src_live(src_live), .fast(fast), .mem_rd(mem_rd), .mem_src(mem_src),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_valid(mem_valid),
    .sink_on(sink_on), .busy(busy));

  function automatic logic [7:0] nv_byte(input int a);
    return 8'((a * 29 + 90) & 255);
  endfunction
  function automatic logic [7:0] live_byte(input int a);
    return 8'((a * 13) & 255) ^ 8'hC3;
  endfunction

  always_ff @(posedge clk) begin
    mem_valid <= mem_rd;
    mem_data  <= mem_src ? live_byte(int'(mem_addr)) : nv_byte(int'(mem_addr));
    if (mem_rd) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sink_on || busy || mem_rd) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  // Decode one frame; returns the byte and the negedge index of its first L half.
  task automatic get_frame(input int div, output logic [7:0] b, output int t0,
                           output bit ok, ref int tnow);
    int wait_n = 0;
    int bad_u = 0, bad_c = 0;
    logic [8:0] bits;
    ok = 0;
    b = 8'h00;
    t0 = 0;
    while (!sink_on) begin
      @(negedge clk);
      tnow++;
      wait_n++;
      if (wait_n > 40 * div) begin
        check(0, "R7 frame start timeout", wait_n, 8 * PB * div);
        return;
      end
    end
    t0 = tnow;
    for (int i = 0; i < 18 * div; i++) begin
      smp[i] = sink_on;
      check(busy == 1'b1, "R11 busy during frame", int'(busy), 1);
      @(negedge clk);
      tnow++;
    end
    for (int k = 0; k < 18; k++)
      for (int j = 1; j < div; j++)
        if (smp[k*div + j] != smp[k*div]) bad_u++;
    for (int k = 0; k < 9; k++) begin
      if (smp[2*k*div] == smp[(2*k+1)*div]) bad_c++;
      bits[8-k] = smp[2*k*div];
    end
    check(bad_u == 0, "R5 half-bit width", bad_u, 0);
    check(bad_c == 0, "R5 manchester halves", bad_c, 0);
    check(bits[8] == 1'b1, "R6 start bit", int'(bits[8]), 1);
    b = bits[7:0];
    ok = 1;
  endtask

  task automatic run_dump(input logic [1:0] md, input bit src, input bit fst,
                          input int a0, input int a1, input bit live, input string req);
    int div = fst ? DF : DS;
    int tnow = 0, tprev = 0, t0;
    logic [7:0] b;
    bit ok;
    @(negedge clk);
    rd_cnt = 0;
    mode = md; src_live = src; fast = fst; test_req = 1'b1;
    for (int a = a0; a <= a1; a++) begin
      get_frame(div, b, t0, ok, tnow);
      if (!ok) return;
      check(b == (live ? live_byte(a) : nv_byte(a)), req, int'(b),
            int'(live ? live_byte(a) : nv_byte(a)));
      if (a > a0)
        check(t0 - tprev == (18 + 2*PB) * div, "R7 frame spacing", t0 - tprev, (18 + 2*PB) * div);
      else
        check(t0 >= 2*PB*div - 1 && t0 <= 2*PB*div + 2, "R7 first gap", t0, 2*PB*div);
      tprev = t0;
    end
    check(rd_cnt == a1 - a0 + 1, "R8 reads per dump", rd_cnt, a1 - a0 + 1);
    check(busy == 1'b0, "R10 busy after last", int'(busy), 0);
    quiet(400, "R10 silent after last frame");
    test_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int tn, t0;
    logic [7:0] b;
    bit ok;
    repeat (3) @(negedge clk);
    check(sink_on == 1'b0 && busy == 1'b0 && mem_rd == 1'b0, "R1 reset state",
          int'({sink_on, busy, mem_rd}), 0);
    rst_n = 1'b1;

    mode = 2'b00; test_req = 1'b1; quiet(300, "R1 mode 00 silent");
    mode = 2'b10; quiet(300, "R1 mode 10 silent");
    test_req = 1'b0; mode = 2'b01; quiet(100, "R1 no request silent");

    run_dump(2'b01, 1'b1, 1'b1, 'h3B, 'h43, 1'b1, "R3 live range data");
    run_dump(2'b01, 1'b0, 1'b0, 'h24, 'h7F, 1'b0, "R2 nv range data");
    run_dump(2'b11, 1'b1, 1'b1, 'h00, 'h7F, 1'b0, "R4 full dump data");

    // Abort mid-frame
    @(negedge clk);
    mode = 2'b11; src_live = 1'b0; fast = 1'b0; test_req = 1'b1;
    tn = 0;
    for (int a = 0; a < 3; a++) get_frame(DS, b, t0, ok, tn);
    while (!sink_on) @(negedge clk);
    repeat (5 * DS) @(negedge clk);
    test_req = 1'b0;
    #1;
    check(sink_on == 1'b0 && busy == 1'b0, "R9 abort mid-frame", int'({sink_on, busy}), 0);
    quiet(100, "R9 stays off after abort");
    test_req = 1'b1;
    tn = 0;
    get_frame(DS, b, t0, ok, tn);
    check(ok && b == nv_byte(0), "R9 restart from first address", int'(b), int'(nv_byte(0)));
    // Abort during the gap
    repeat (3) @(negedge clk);
    check(busy == 1'b1 && sink_on == 1'b0, "R7 gap is Z with busy", int'({busy, sink_on}), 2);
    test_req = 1'b0;
    #1;
    check(sink_on == 1'b0 && busy == 1'b0 && mem_rd == 1'b0, "R9 abort in gap",
          int'({sink_on, busy, mem_rd}), 0);
    quiet(50, "R9 quiet after gap abort");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule